// File: doc/BRIEF.md
# Rank Interleave DIMM Decoder

This block turns an address local to one memory channel into the DIMM, the rank within that DIMM and the address local to that rank. It compares the address against an ordered list of rank interleave rules. From the matching rule it selects an entry that holds a physical rank target and an offset. The rule's way count and the page mode decide which address bits pick the entry and which bits are removed when the interleave is undone.

Every decode ends in a result code. The DIMM configuration can reject a decode because the DIMM number is out of range, because the DIMM is absent, or because the rank does not exist on that DIMM. An offset larger than the de-interleaved address is also rejected. A request is one cycle of `req_valid_i` together with the address. The registered result appears with `rsp_valid_o` one cycle later. The configuration inputs are static levels, driven by whatever logic owns the channel setup.

Top module: `rir_dimm_decoder`

## Requirements
- R1: The rules are scanned from index 0 upward. The base of rule i is the limit of rule i-1, and the base of rule 0 is zero. A disabled rule still passes its limit on as the next base. The first enabled rule with base <= address < limit is selected. If no rule matches, the result code is 1.
- R2: The interleave shift is 6 when `page_closed_i` is 1 and 13 when it is 0.
- R3: The way count of a rule is 2^w, where w is the rule's 2-bit field in `rule_ways_i`. The entry index is the address shifted right by the interleave shift, taken modulo the way count. If the index is equal to or greater than the rule's 4-bit entry count in `rule_nent_i`, the result code is 2.
- R4: The 4-bit rank target of the selected entry is split in two. Bits [3:2] give the DIMM number and bits [1:0] give the rank number. Every DIMM therefore owns four target codes, whatever number of ranks it actually has.
- R5: A DIMM number of 3 or more gives result code 3. A DIMM whose `dimm_present_i` bit is 0 gives code 4. A rank number equal to or greater than that DIMM's 3-bit rank count gives code 5.
- R6: The intermediate address is formed in three steps. The part of the address above the shift is shifted right by the shift. It is then divided by the way count and moved back into place. Finally the low shift bits of the original address are ORed in.
- R7: The selected entry's offset is subtracted from the intermediate address to give the rank address. An offset greater than the intermediate address gives result code 6. An offset equal to the intermediate address is legal and yields 0.
- R8: When more than one failure applies, the lowest-numbered failure in the order 1 to 6 is reported. After any failure, the DIMM, rank and rank address outputs are 0. Code 0 means success.
- R9: `rsp_valid_o` is high exactly in the cycle after `req_valid_i` was sampled high. After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Decode request strobe |
| req_addr_i | input | 40 | Channel-local address |
| page_closed_i | input | 1 | 1 selects the closed-page shift, 0 the open-page shift |
| rule_en_i | input | 6 | Enable bit for each rule |
| rule_limit_i | input | 240 | Exclusive limit for each rule, 40 bits per rule |
| rule_ways_i | input | 12 | log2 of the way count for each rule, 2 bits per rule |
| rule_nent_i | input | 24 | Valid entry count for each rule, 4 bits per rule |
| ent_tgt_i | input | 192 | Rank target for each entry, 4 bits, rule-major |
| ent_off_i | input | 1920 | Offset for each entry, 40 bits, rule-major |
| dimm_present_i | input | 3 | Presence bit for each DIMM |
| dimm_nranks_i | input | 9 | Rank count for each DIMM, 3 bits per DIMM |
| rsp_valid_o | output | 1 | Result strobe |
| fail_o | output | 3 | Result code, 0 for success |
| dimm_o | output | 2 | DIMM number |
| rank_o | output | 2 | Rank within the DIMM |
| rank_addr_o | output | 40 | Rank-local address |

## Verification
All results, including the code, DIMM, rank and rank address, come from a single register stage. They are due in the cycle after the request edge. The driver raises a request on a falling edge and pushes the expected result into a queue. The monitor samples on the next falling edge, which is half a period after the capturing edge, and compares the popped item only when `rsp_valid_o` is high. A strobe that arrives with nothing expected, or in a cycle with no request, is reported as a mismatch.

// File: rtl/rir_dec_pkg.sv
package rir_dec_pkg;
  typedef enum logic [2:0] {
    RIR_OK        = 3'd0,
    RIR_NO_RULE   = 3'd1,
    RIR_BAD_TGT   = 3'd2,
    RIR_BAD_DIMM  = 3'd3,
    RIR_NO_DIMM   = 3'd4,
    RIR_BAD_RANK  = 3'd5,
    RIR_UNDERFLOW = 3'd6
  } rir_fail_e;

  localparam int unsigned CLOSED_SHIFT = 6;
  localparam int unsigned OPEN_SHIFT   = 13;
endpackage

// File: rtl/rir_rule_match.sv
module rir_rule_match #(
  parameter int unsigned NUM_RULES = 6,
  parameter int unsigned ADDR_W    = 40,
  localparam int unsigned RIDX_W   = $clog2(NUM_RULES)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [NUM_RULES-1:0]          rule_en_i,
  input  logic [NUM_RULES*ADDR_W-1:0]   rule_limit_i,
  output logic                          hit_o,
  output logic [RIDX_W-1:0]             idx_o
);
  always_comb begin
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] lim;
    hit_o = 1'b0;
    idx_o = '0;
    base  = '0;
    for (int i = 0; i < NUM_RULES; i++) begin
      lim = rule_limit_i[i*ADDR_W +: ADDR_W];
      if (!hit_o && rule_en_i[i] && addr_i >= base && addr_i < lim) begin
        hit_o = 1'b1;
        idx_o = RIDX_W'(i);
      end
      base = lim;
    end
  end

  assert_hit_below_limit_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (addr_i < rule_limit_i[idx_o*ADDR_W +: ADDR_W]) && rule_en_i[idx_o]);
endmodule

// File: rtl/rir_rank_calc.sv
module rir_rank_calc
  import rir_dec_pkg::*;
#(
  parameter int unsigned ADDR_W    = 40,
  parameter int unsigned NUM_ENT   = 8,
  parameter int unsigned NUM_DIMMS = 3,
  parameter int unsigned TGT_W     = 4,
  parameter int unsigned WAYS_W    = 2,
  parameter int unsigned NRK_W     = 3,
  localparam int unsigned CNT_W    = $clog2(NUM_ENT + 1),
  localparam int unsigned ENT_W    = $clog2(NUM_ENT),
  localparam int unsigned DIMM_W   = TGT_W - 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic                         page_closed_i,
  input  logic                         hit_i,
  input  logic [WAYS_W-1:0]            ways_log2_i,
  input  logic [CNT_W-1:0]             nent_i,
  input  logic [NUM_ENT*TGT_W-1:0]     tgts_i,
  input  logic [NUM_ENT*ADDR_W-1:0]    offs_i,
  input  logic [NUM_DIMMS-1:0]         dimm_present_i,
  input  logic [NUM_DIMMS*NRK_W-1:0]   dimm_nranks_i,
  output rir_fail_e                    fail_o,
  output logic [DIMM_W-1:0]            dimm_o,
  output logic [1:0]                   rank_o,
  output logic [ADDR_W-1:0]            rank_addr_o
);
  logic [5:0]        shift;
  logic [ADDR_W-1:0] low_mask, sel_idx, mid_addr, off;
  logic [ENT_W-1:0]  ent;
  logic [TGT_W-1:0]  tgt;
  logic              present;
  logic [NRK_W-1:0]  nranks;

  assign shift    = page_closed_i ? 6'(CLOSED_SHIFT) : 6'(OPEN_SHIFT);
  assign low_mask = (ADDR_W'(1) << shift) - ADDR_W'(1);
  assign sel_idx  = (addr_i >> shift) & ((ADDR_W'(1) << ways_log2_i) - ADDR_W'(1));
  assign ent      = sel_idx[ENT_W-1:0];
  assign tgt      = tgts_i[ent*TGT_W +: TGT_W];
  assign off      = offs_i[ent*ADDR_W +: ADDR_W];
  assign mid_addr = (((addr_i >> shift) >> ways_log2_i) << shift) | (addr_i & low_mask);
  assign dimm_o   = tgt[TGT_W-1:2];
  assign rank_o   = tgt[1:0];

  always_comb begin
    present = 1'b0;
    nranks  = '0;
    for (int d = 0; d < NUM_DIMMS; d++) begin
      if (dimm_o == DIMM_W'(d)) begin
        present = dimm_present_i[d];
        nranks  = dimm_nranks_i[d*NRK_W +: NRK_W];
      end
    end
  end

  always_comb begin
    if (!hit_i)                                  fail_o = RIR_NO_RULE;
    else if (sel_idx >= ADDR_W'(nent_i))         fail_o = RIR_BAD_TGT;
    else if (32'(dimm_o) >= NUM_DIMMS)           fail_o = RIR_BAD_DIMM;
    else if (!present)                           fail_o = RIR_NO_DIMM;
    else if ({1'b0, rank_o} >= 3'(nranks))       fail_o = RIR_BAD_RANK;
    else if (off > mid_addr)                     fail_o = RIR_UNDERFLOW;
    else                                         fail_o = RIR_OK;
  end

  assign rank_addr_o = mid_addr - off;

  assert_rank_addr_bounded_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_o == RIR_OK) |-> (rank_addr_o <= addr_i));
  assert_ok_rank_exists_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_o == RIR_OK) |-> (32'(dimm_o) < NUM_DIMMS) && ({1'b0, rank_o} < 3'(nranks)));
endmodule

// File: rtl/rir_dimm_decoder.sv
module rir_dimm_decoder
  import rir_dec_pkg::*;
#(
  parameter int unsigned ADDR_W    = 40,
  parameter int unsigned NUM_RULES = 6,
  parameter int unsigned NUM_ENT   = 8,
  parameter int unsigned NUM_DIMMS = 3,
  parameter int unsigned TGT_W     = 4,
  parameter int unsigned WAYS_W    = 2,
  parameter int unsigned NRK_W     = 3,
  localparam int unsigned CNT_W    = $clog2(NUM_ENT + 1),
  localparam int unsigned RIDX_W   = $clog2(NUM_RULES),
  localparam int unsigned DIMM_W   = TGT_W - 2
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                req_valid_i,
  input  logic [ADDR_W-1:0]                   req_addr_i,
  input  logic                                page_closed_i,
  input  logic [NUM_RULES-1:0]                rule_en_i,
  input  logic [NUM_RULES*ADDR_W-1:0]         rule_limit_i,
  input  logic [NUM_RULES*WAYS_W-1:0]         rule_ways_i,
  input  logic [NUM_RULES*CNT_W-1:0]          rule_nent_i,
  input  logic [NUM_RULES*NUM_ENT*TGT_W-1:0]  ent_tgt_i,
  input  logic [NUM_RULES*NUM_ENT*ADDR_W-1:0] ent_off_i,
  input  logic [NUM_DIMMS-1:0]                dimm_present_i,
  input  logic [NUM_DIMMS*NRK_W-1:0]          dimm_nranks_i,
  output logic                                rsp_valid_o,
  output logic [2:0]                          fail_o,
  output logic [DIMM_W-1:0]                   dimm_o,
  output logic [1:0]                          rank_o,
  output logic [ADDR_W-1:0]                   rank_addr_o
);
  logic              hit;
  logic [RIDX_W-1:0] ridx;
  rir_fail_e         c_fail;
  logic [DIMM_W-1:0] c_dimm;
  logic [1:0]        c_rank;
  logic [ADDR_W-1:0] c_raddr;

  rir_rule_match #(.NUM_RULES(NUM_RULES), .ADDR_W(ADDR_W)) u_match (
    .clk_i, .rst_ni,
    .addr_i       (req_addr_i),
    .rule_en_i    (rule_en_i),
    .rule_limit_i (rule_limit_i),
    .hit_o        (hit),
    .idx_o        (ridx)
  );

  rir_rank_calc #(
    .ADDR_W(ADDR_W), .NUM_ENT(NUM_ENT), .NUM_DIMMS(NUM_DIMMS),
    .TGT_W(TGT_W), .WAYS_W(WAYS_W), .NRK_W(NRK_W)
  ) u_calc (
    .clk_i, .rst_ni,
    .addr_i         (req_addr_i),
    .page_closed_i  (page_closed_i),
    .hit_i          (hit),
    .ways_log2_i    (rule_ways_i[ridx*WAYS_W +: WAYS_W]),
    .nent_i         (rule_nent_i[ridx*CNT_W +: CNT_W]),
    .tgts_i         (ent_tgt_i[ridx*NUM_ENT*TGT_W +: NUM_ENT*TGT_W]),
    .offs_i         (ent_off_i[ridx*NUM_ENT*ADDR_W +: NUM_ENT*ADDR_W]),
    .dimm_present_i (dimm_present_i),
    .dimm_nranks_i  (dimm_nranks_i),
    .fail_o         (c_fail),
    .dimm_o         (c_dimm),
    .rank_o         (c_rank),
    .rank_addr_o    (c_raddr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      fail_o      <= '0;
      dimm_o      <= '0;
      rank_o      <= '0;
      rank_addr_o <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      if (req_valid_i) begin
        fail_o <= c_fail;
        if (c_fail == RIR_OK) begin
          dimm_o      <= c_dimm;
          rank_o      <= c_rank;
          rank_addr_o <= c_raddr;
        end else begin
          dimm_o      <= '0;
          rank_o      <= '0;
          rank_addr_o <= '0;
        end
      end
    end
  end

  assert_rsp_follows_req_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  assert_no_spurious_rsp_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);
  assert_fail_clears_fields_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && fail_o != 3'd0) |-> (dimm_o == '0 && rank_o == '0 && rank_addr_o == '0));
endmodule

// File: tb/tb_rir_dimm_decoder.sv
`timescale 1ns/1ps
module tb_rir_dimm_decoder;
  localparam int AW = 40, NR = 6, NE = 8, ND = 3;

  typedef struct {
    logic [2:0]    f;
    logic [1:0]    d;
    logic [1:0]    r;
    logic [AW-1:0] a;
    string         tag;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr  = '0;
  logic          closed    = 1'b1;

  logic          en   [NR];
  logic [AW-1:0] lim  [NR];
  logic [1:0]    wl   [NR];
  logic [3:0]    nent [NR];
  logic [3:0]    tgt  [NR][NE];
  logic [AW-1:0] off  [NR][NE];
  logic          pres [ND];
  logic [2:0]    nrk  [ND];

  logic [NR-1:0]       en_f;
  logic [NR*AW-1:0]    lim_f;
  logic [NR*2-1:0]     wl_f;
  logic [NR*4-1:0]     nent_f;
  logic [NR*NE*4-1:0]  tgt_f;
  logic [NR*NE*AW-1:0] off_f;
  logic [ND-1:0]       pres_f;
  logic [ND*3-1:0]     nrk_f;

  always_comb begin
    for (int r = 0; r < NR; r++) begin
      en_f[r]           = en[r];
      lim_f[r*AW +: AW] = lim[r];
      wl_f[r*2 +: 2]    = wl[r];
      nent_f[r*4 +: 4]  = nent[r];
      for (int e = 0; e < NE; e++) begin
        tgt_f[(r*NE+e)*4 +: 4]   = tgt[r][e];
        off_f[(r*NE+e)*AW +: AW] = off[r][e];
      end
    end
    for (int d = 0; d < ND; d++) begin
      pres_f[d]      = pres[d];
      nrk_f[d*3 +: 3] = nrk[d];
    end
  end

  logic          rsp_valid;
  logic [2:0]    fail;
  logic [1:0]    dimm, rank;
  logic [AW-1:0] raddr;

  rir_dimm_decoder dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_addr_i(req_addr), .page_closed_i(closed),
    .rule_en_i(en_f), .rule_limit_i(lim_f), .rule_ways_i(wl_f), .rule_nent_i(nent_f),
    .ent_tgt_i(tgt_f), .ent_off_i(off_f),
    .dimm_present_i(pres_f), .dimm_nranks_i(nrk_f),
    .rsp_valid_o(rsp_valid), .fail_o(fail), .dimm_o(dimm), .rank_o(rank),
    .rank_addr_o(raddr)
  );

  int   n_checks = 0, n_fail = 0;
  bit   done = 1'b0;
  exp_t sb[$];

  // reference decode written from the requirements
  function automatic exp_t model(logic [AW-1:0] a, logic cl, string tag);
    exp_t          x;
    int            s, hit, ways, idx, dd, rk;
    logic [AW-1:0] base, mid, unit;
    x.f = 3'd0; x.d = '0; x.r = '0; x.a = '0; x.tag = tag;
    s = cl ? 6 : 13;
    hit = -1; base = '0;
    for (int r = 0; r < NR; r++) begin
      if (hit < 0 && en[r] && a >= base && a < lim[r]) hit = r;
      base = lim[r];
    end
    if (hit < 0) begin x.f = 3'd1; return x; end
    ways = 1 << wl[hit];
    idx  = int'((a >> s) % AW'(ways));
    if (idx >= int'(nent[hit])) begin x.f = 3'd2; return x; end
    dd = int'(tgt[hit][idx]) / 4;
    rk = int'(tgt[hit][idx]) % 4;
    if (dd >= ND)               begin x.f = 3'd3; return x; end
    if (!pres[dd])              begin x.f = 3'd4; return x; end
    if (rk >= int'(nrk[dd]))    begin x.f = 3'd5; return x; end
    unit = AW'(1) << s;
    mid  = ((a >> s) / AW'(ways)) * unit + (a % unit);
    if (off[hit][idx] > mid)    begin x.f = 3'd6; return x; end
    x.d = 2'(dd); x.r = 2'(rk); x.a = mid - off[hit][idx];
    return x;
  endfunction

  task automatic send(input logic [AW-1:0] a, input string tag);
    @(negedge clk);
    req_addr  = a;
    req_valid = 1'b1;
    sb.push_back(model(a, closed, tag));
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor: results are due one edge after the request, sampled on the falling edge
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      n_checks++;
      if (sb.size() == 0) begin
        n_fail++;
        $display("FAIL R9 unexpected rsp_valid: actual 1 expected 0");
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (fail !== e.f || dimm !== e.d || rank !== e.r || raddr !== e.a) begin
          n_fail++;
          $display("FAIL %s actual f=%0d d=%0d r=%0d a=%h expected f=%0d d=%0d r=%0d a=%h",
                   e.tag, fail, dimm, rank, raddr, e.f, e.d, e.r, e.a);
        end
      end
    end
  end

  task automatic chk(input bit ok, input string msg);
    n_checks++;
    if (!ok) begin n_fail++; $display("FAIL %s", msg); end
  endtask

  initial begin
    for (int r = 0; r < NR; r++) begin
      en[r] = 1'b1; wl[r] = '0; nent[r] = '0;
      for (int e = 0; e < NE; e++) begin tgt[r][e] = '0; off[r][e] = '0; end
    end
    lim[0] = 40'h00_1000_0000; wl[0] = 2'd1; nent[0] = 4'd2;
    tgt[0][0] = 4'd0; tgt[0][1] = 4'd1;
    lim[1] = 40'h00_2000_0000; en[1] = 1'b0; nent[1] = 4'd1;
    lim[2] = 40'h00_4000_0000; wl[2] = 2'd2; nent[2] = 4'd3;
    tgt[2][0] = 4'd4; tgt[2][1] = 4'd5; tgt[2][2] = 4'd8;
    off[2][0] = 40'h00_0800_0000; off[2][1] = 40'h100;
    lim[3] = 40'h00_8000_0000; nent[3] = 4'd1; tgt[3][0] = 4'd12;
    lim[4] = 40'h00_9000_0000; wl[4] = 2'd3; nent[4] = 4'd8;
    for (int e = 0; e < NE; e++) begin tgt[4][e] = 4'(e); off[4][e] = 40'h40; end
    off[4][0] = 40'hFF_FFFF_FFFF;
    lim[5] = 40'h00_A000_0000; nent[5] = 4'd0;
    pres[0] = 1'b1; nrk[0] = 3'd2;
    pres[1] = 1'b1; nrk[1] = 3'd4;
    pres[2] = 1'b0; nrk[2] = 3'd4;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_valid === 1'b0 && fail === 3'd0 && dimm === 2'd0 && rank === 2'd0 && raddr === '0,
        $sformatf("R9 reset state: actual v=%0d f=%0d a=%h expected all 0", rsp_valid, fail, raddr));

    // closed page
    send(40'h00_0000_0040, "R3 R4 rule0 odd index");
    send(40'h00_0000_0000, "R6 rule0 index 0");
    send(40'h00_0123_4567, "R6 rule0 low bits kept");
    send(40'h00_0FFF_FFFF, "R1 last address of rule0");
    send(40'h00_1000_0000, "R1 first address of disabled rule");
    send(40'h00_1800_0000, "R1 inside disabled rule");
    send(40'h00_2000_0000, "R7 offset equal to intermediate");
    send(40'h00_2000_0040, "R7 offset subtract");
    send(40'h00_2000_0080, "R5 DIMM not present");
    send(40'h00_2000_00C0, "R3 index beyond entry count");
    send(40'h00_4000_1234, "R5 DIMM number out of range");
    send(40'h00_8000_0080, "R5 rank beyond DIMM rank count");
    send(40'h00_8000_0000, "R7 offset underflow");
    send(40'h00_8000_0140, "R6 eight way rule");
    send(40'h00_9FFF_FFFF, "R8 rule with no entries");
    send(40'h00_A000_0000, "R1 above all limits");
    @(negedge clk);
    chk(rsp_valid === 1'b0, $sformatf("R9 idle cycle: actual %0d expected 0", rsp_valid));

    // open page
    closed = 1'b0;
    send(40'h00_0000_2040, "R2 open page rule0 index 1");
    send(40'h00_0000_0040, "R2 open page bit 6 ignored");
    send(40'h00_8000_A000, "R2 open page eight way");
    send(40'h00_2000_6000, "R2 open page bad index");
    repeat (3) @(negedge clk);
    chk(sb.size() == 0, $sformatf("R9 pending results: actual %0d expected 0", sb.size()));

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL R9 watchdog expired: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule